// File: doc/BRIEF.md
# Long Packet Byte-Stream Assembler

This block turns a packet request and a stream of payload bytes into the serial byte sequence of one link-layer packet. A request carries a 2-bit virtual channel, a 6-bit data type, a 16-bit length/data field and a flag that selects a long or a short packet. The assembler first sends a 4-byte header: the identifier byte, the two bytes of the 16-bit field (low byte first) and an error-correcting byte that a companion encoder computes over those three bytes.

For a long packet the 16-bit field is the word count. The assembler then passes exactly that many payload bytes from its payload input to its output, updating a reflected 16-bit CRC one byte per clock. It closes the packet with a 2-byte footer holding the CRC, or zero when the checksum is switched off. A short packet ends after its header, and the payload input is left untouched. If the payload source ends early, the assembler pads the packet with zero bytes. If the source sends too many bytes, the extra bytes are discarded. In both cases a length-error flag is raised, and the packet on the wire always keeps the length it announced.

Top module: `pkt_assembler`

## Requirements
- R1: After reset the block is idle. `hdr_ready` is high only while idle. The first output byte of every packet is the identifier, with the virtual channel in bits 7:6 and the data type in bits 5:0.
- R2: The second and third output bytes are `hdr_wc[7:0]` and then `hdr_wc[15:8]`.
- R3: The fourth byte is the ECC. Bits 7:6 are 0. Each bit i (0 to 5) is the XOR of the 24-bit word d = {byte3, byte2, identifier}, taken over these bit positions:
  - bit 0: d0,1,2,4,5,7,10,11,13,16,20,21,22,23
  - bit 1: d0,1,3,4,6,8,10,12,14,17,20,21,22,23
  - bit 2: d0,2,3,5,6,9,11,12,15,18,20,21,22
  - bit 3: d1,2,3,7,8,9,13,14,15,19,20,21,23
  - bit 4: d4..9,16..20,22,23
  - bit 5: d10..19,21,22,23
- R4: A long packet forwards exactly `hdr_wc` payload bytes, unchanged and in order, after the ECC byte. `pl_ready` is high only during the payload phase, or while excess bytes are being discarded.
- R5: With the checksum enabled, the footer is a CRC computed over the sent payload bytes. The register starts at FFFFh. For each byte, the byte is XORed into the low 8 bits, then 8 times the register is shifted right and XORed with 8408h whenever the bit shifted out is 1. The footer is sent low byte first.
- R6: A long packet with word count 0 consumes no payload bytes, and with the checksum enabled its footer is FFh, FFh.
- R7: With `cfg_crc_en` low when the request is accepted, the footer is 00h, 00h.
- R8: A short packet is exactly 4 bytes, with no payload and no footer, and it consumes no payload bytes.
- R9: If `pl_last` arrives on a byte before the final counted byte, the remaining payload positions are sent as 00h and included in the CRC, `pl_ready` stays low for them, and `len_err` is set.
- R10: If the final counted byte is accepted without `pl_last`, the following payload bytes are discarded up to and including the one marked `pl_last`, `len_err` is set, and the footer covers only the counted bytes.
- R11: `pkt_done` pulses for exactly the cycle in which the last byte of the packet is accepted. That is the footer high byte for a long packet and the ECC byte for a short one.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` holds its value.
- R13: `len_err` is cleared when a request is accepted, and it holds its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_crc_en | input | 1 | Checksum enable, sampled when a request is accepted |
| hdr_valid | input | 1 | Packet request valid |
| hdr_ready | output | 1 | Request accepted (idle) |
| hdr_vc | input | 2 | Virtual channel |
| hdr_dt | input | 6 | Data type |
| hdr_wc | input | 16 | Word count (long) or two data bytes (short) |
| hdr_long | input | 1 | 1 = long packet, 0 = short packet |
| pl_valid | input | 1 | Payload byte valid |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| pl_last | input | 1 | Marks the final payload byte from the source |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| pkt_done | output | 1 | Last byte of the packet accepted |
| len_err | output | 1 | Payload source length did not match the word count |

## Verification
On every cycle the assertions check these properties:
- `hdr_ready` excludes both output and payload traffic.
- Header and footer bytes stay stable while stalled.
- Padding bytes are zero and are never paired with `pl_ready`.
- The number of payload bytes sent matches the word count.
- `pkt_done` coincides with an output handshake and is followed by idle.
- A zero-length packet puts FFh on the output right after its ECC byte.

The byte values themselves need the bench's scenarios, which compare every output byte against a reference stream:
- ECC values for several headers
- CRC footers under random stalls
- the disabled-checksum footer
- short packets
- early and late ends of the payload source, with the resulting `len_err`

// File: rtl/pkt_asm_pkg.sv
// Shared constants and the sequencer state type for the long packet assembler.
package pkt_asm_pkg;
    localparam int BYTE_W   = 8;
    localparam int WC_W     = 16;
    localparam int VC_W     = 2;
    localparam int DT_W     = 6;
    localparam int CRC_W    = 16;
    localparam int ECC_IN_W = 3 * BYTE_W;
    localparam int PAR_W    = 6;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h8408;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ID, ST_WC_LO, ST_WC_HI, ST_ECC,
        ST_PAY, ST_DRAIN, ST_CK_LO, ST_CK_HI
    } asm_state_e;
endpackage

// File: rtl/pkt_hdr_ecc.sv
// Header ECC encoder: 6 parity bits over a 24-bit header word.
// The top two bits are always 0.
// Assumes the header word is {byte3, byte2, identifier}.
module pkt_hdr_ecc
    import pkt_asm_pkg::*;
(
    input  logic [ECC_IN_W-1:0] hdr_word,
    output logic [BYTE_W-1:0]   ecc
);
    localparam logic [ECC_IN_W-1:0] PAR_MASK [PAR_W] = '{
        24'hF12CB7, 24'hF2555B, 24'h749A6D,
        24'hB8E38E, 24'hDF03F0, 24'hEFFC00
    };

    genvar gi;
    generate
        for (gi = 0; gi < PAR_W; gi++) begin : g_par
            // Parity bit gi covers the header bits selected by its mask.
            assign ecc[gi] = ^(hdr_word & PAR_MASK[gi]);
        end
        for (gi = PAR_W; gi < BYTE_W; gi++) begin : g_zero
            assign ecc[gi] = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pkt_crc16_byte.sv
// One-byte update of a reflected CRC, LSB first, unrolled into 8 bit steps.
// Assumes the caller registers the result.
module pkt_crc16_byte
    import pkt_asm_pkg::*;
#(
    parameter int               W    = CRC_W,
    parameter logic [W-1:0]     POLY = CRC_POLY
) (
    input  logic [W-1:0]      crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [W-1:0]      crc_out
);
    logic [W-1:0] stage [BYTE_W+1];

    assign stage[0] = crc_in ^ {{(W-BYTE_W){1'b0}}, data_in};

    genvar gs;
    generate
        for (gs = 0; gs < BYTE_W; gs++) begin : g_step
            // Shift one bit out; fold in the polynomial when that bit was 1.
            assign stage[gs+1] = stage[gs][0] ? ((stage[gs] >> 1) ^ POLY)
                                              : (stage[gs] >> 1);
        end
    endgenerate

    assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/pkt_assembler.sv
// Long/short packet assembler.
// Sends the identifier, the 16-bit field (low byte first) and the ECC.
// For a long packet it then forwards exactly word-count payload bytes
// and appends a CRC footer (low byte first), or 0000h when the checksum
// is disabled.
// Assumes downstream applies valid/ready on every byte. The payload path
// is combinational (no buffering).
module pkt_assembler
    import pkt_asm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_crc_en,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [VC_W-1:0]   hdr_vc,
    input  logic [DT_W-1:0]   hdr_dt,
    input  logic [WC_W-1:0]   hdr_wc,
    input  logic              hdr_long,
    input  logic              pl_valid,
    output logic              pl_ready,
    input  logic [BYTE_W-1:0] pl_data,
    input  logic              pl_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              pkt_done,
    output logic              len_err
);
    asm_state_e        state;
    logic [BYTE_W-1:0] id_q;
    logic [WC_W-1:0]   wc_q;
    logic [WC_W-1:0]   rem_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_nxt;
    logic [CRC_W-1:0]  footer;
    logic [BYTE_W-1:0] ecc_byte;
    logic              long_q, en_q, pad_q, err_q;
    logic              hdr_fire, out_fire, pl_fire, last_slot;

    pkt_hdr_ecc u_ecc (
        .hdr_word ({wc_q, id_q}),
        .ecc      (ecc_byte)
    );

    pkt_crc16_byte u_crc (
        .crc_in  (crc_q),
        .data_in (out_data),
        .crc_out (crc_nxt)
    );

    assign hdr_ready = (state == ST_IDLE);
    assign hdr_fire  = hdr_valid && hdr_ready;
    assign out_fire  = out_valid && out_ready;
    assign pl_fire   = pl_valid && pl_ready;
    assign last_slot = (rem_q == {{(WC_W-1){1'b0}}, 1'b1});
    assign footer    = en_q ? crc_q : '0;
    assign len_err   = err_q;

    // Handshake: payload is taken while forwarding, or while discarding excess bytes.
    always_comb begin
        pl_ready  = 1'b0;
        out_valid = 1'b0;
        case (state)
            ST_ID, ST_WC_LO, ST_WC_HI, ST_ECC, ST_CK_LO, ST_CK_HI: out_valid = 1'b1;
            ST_PAY: begin
                out_valid = pad_q ? 1'b1 : pl_valid;
                pl_ready  = !pad_q && out_ready;
            end
            ST_DRAIN: pl_ready = 1'b1;
            default: ;
        endcase
    end

    // Output byte select for the current phase.
    always_comb begin
        case (state)
            ST_ID:    out_data = id_q;
            ST_WC_LO: out_data = wc_q[BYTE_W-1:0];
            ST_WC_HI: out_data = wc_q[WC_W-1:BYTE_W];
            ST_ECC:   out_data = ecc_byte;
            ST_PAY:   out_data = pad_q ? '0 : pl_data;
            ST_CK_LO: out_data = footer[BYTE_W-1:0];
            ST_CK_HI: out_data = footer[CRC_W-1:BYTE_W];
            default:  out_data = '0;
        endcase
    end

    // Done pulse on the final byte's handshake.
    assign pkt_done = out_fire && ((state == ST_CK_HI) || (state == ST_ECC && !long_q));

    // Sequencer, byte counter, CRC register and length-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            id_q   <= '0;
            wc_q   <= '0;
            rem_q  <= '0;
            crc_q  <= CRC_SEED;
            long_q <= 1'b0;
            en_q   <= 1'b0;
            pad_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (hdr_fire) begin
                    id_q   <= {hdr_vc, hdr_dt};
                    wc_q   <= hdr_wc;
                    rem_q  <= hdr_wc;
                    long_q <= hdr_long;
                    en_q   <= cfg_crc_en;
                    crc_q  <= CRC_SEED;
                    pad_q  <= 1'b0;
                    err_q  <= 1'b0;
                    state  <= ST_ID;
                end
                ST_ID:    if (out_fire) state <= ST_WC_LO;
                ST_WC_LO: if (out_fire) state <= ST_WC_HI;
                ST_WC_HI: if (out_fire) state <= ST_ECC;
                ST_ECC: if (out_fire) begin
                    if (!long_q)          state <= ST_IDLE;
                    else if (wc_q == '0)  state <= ST_CK_LO;
                    else                  state <= ST_PAY;
                end
                ST_PAY: if (out_fire) begin
                    crc_q <= crc_nxt;
                    rem_q <= rem_q - 1'b1;
                    if (last_slot) begin
                        if (!pad_q && !pl_last) begin
                            err_q <= 1'b1;
                            state <= ST_DRAIN;
                        end else begin
                            state <= ST_CK_LO;
                        end
                    end else if (!pad_q && pl_last) begin
                        err_q <= 1'b1;
                        pad_q <= 1'b1;
                    end
                end
                ST_DRAIN: if (pl_fire && pl_last) state <= ST_CK_LO;
                ST_CK_LO: if (out_fire) state <= ST_CK_HI;
                ST_CK_HI: if (out_fire) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Checker counter: payload bytes sent in the current packet.
    logic [WC_W:0] sent_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || hdr_fire) sent_cnt <= '0;
        else if (state == ST_PAY && out_fire) sent_cnt <= sent_cnt + 1'b1;
    end

    assert_idle_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ready |-> (!out_valid && !pl_ready));

    assert_payload_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CK_LO && out_fire && long_q) |-> (sent_cnt == {1'b0, wc_q}));

    assert_empty_footer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ECC && out_fire && long_q && wc_q == '0 && en_q)
        |=> (out_valid && out_data == 8'hFF));

    assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAY && pad_q) |-> (out_valid && out_data == '0 && !pl_ready));

    assert_done_handshake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (out_valid && out_ready));

    assert_done_then_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> hdr_ready);

    assert_hold_on_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && state != ST_PAY) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/sim_pkt_assembler.sv
// Scoreboard bench. Tasks queue the expected output bytes and the payload
// source bytes; a monitor compares every valid output byte.
module sim_pkt_assembler;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_crc_en = 1'b1;
    logic       hdr_valid = 1'b0;
    logic       hdr_ready;
    logic [1:0] hdr_vc = '0;
    logic [5:0] hdr_dt = '0;
    logic [15:0] hdr_wc = '0;
    logic       hdr_long = 1'b0;
    logic       pl_valid = 1'b0;
    logic       pl_ready;
    logic [7:0] pl_data = '0;
    logic       pl_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       pkt_done;
    logic       len_err;

    pkt_assembler u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] exp_q[$];
    bit         exp_last_q[$];
    string      exp_tag_q[$];
    logic [7:0] feed_q[$];
    bit         feed_last_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit stall_en = 1'b0;
    bit gap_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    function automatic logic [7:0] ecc_ref(input logic [23:0] d);
        logic [7:0] p;
        p[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
        p[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
        p[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
        p[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
        p[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
        p[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
        p[7:6] = 2'b00;
        return p;
    endfunction

    task automatic expect_byte(input logic [7:0] b, input bit last, input string tag);
        exp_q.push_back(b);
        exp_last_q.push_back(last);
        exp_tag_q.push_back(tag);
    endtask

    // Queue one packet's expected bytes and its payload source, issue the
    // request, wait for completion, then check the length-error flag.
    task automatic send_pkt(input logic [1:0] vc, input logic [5:0] dt, input int wc,
                            input bit lng, input bit en, input int supplied,
                            input logic [7:0] seed);
        logic [7:0]  id;
        logic [15:0] crc;
        logic [7:0]  b;
        bit          err_exp;
        id = {vc, dt};
        crc = 16'hFFFF;
        expect_byte(id, 1'b0, "R1");
        expect_byte(wc[7:0], 1'b0, "R2");
        expect_byte(wc[15:8], 1'b0, "R2");
        expect_byte(ecc_ref({wc[15:0], id}), !lng, "R3");
        err_exp = lng && (wc > 0) && (supplied != wc);
        if (lng) begin
            for (int i = 0; i < supplied; i++) begin
                feed_q.push_back(seed + 8'(i * 7));
                feed_last_q.push_back(i == supplied - 1);
            end
            for (int i = 0; i < wc; i++) begin
                b = (i < supplied) ? (seed + 8'(i * 7)) : 8'h00;
                crc = crc_ref(crc, b);
                expect_byte(b, 1'b0, (i < supplied) ? "R4" : "R9");
            end
            if (!en) crc = 16'h0000;
            expect_byte(crc[7:0],  1'b0, (wc == 0) ? "R6" : (en ? "R5" : "R7"));
            expect_byte(crc[15:8], 1'b1, (wc == 0) ? "R6" : (en ? "R5" : "R7"));
        end
        @(posedge clk); #1;
        hdr_valid = 1'b1; hdr_vc = vc; hdr_dt = dt; hdr_wc = wc[15:0];
        hdr_long = lng; cfg_crc_en = en;
        @(negedge clk);
        while (!hdr_ready) @(negedge clk);
        @(posedge clk); #1;
        hdr_valid = 1'b0;
        cfg_crc_en = ~en;
        @(negedge clk);
        while (exp_q.size() != 0 || !hdr_ready) @(negedge clk);
        check(len_err == err_exp, supplied > wc ? "R10" : "R9", "len_err", len_err, err_exp);
        check(feed_q.size() == 0, lng ? "R10" : "R8", "source bytes left", feed_q.size(), 0);
    endtask

    // Monitor: every valid output byte must equal the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected byte", out_data, 0);
                end else begin
                    check(out_data == exp_q[0], exp_tag_q[0], "byte", out_data, exp_q[0]);
                    if (out_ready) begin
                        check(pkt_done == exp_last_q[0], "R11", "pkt_done", pkt_done, exp_last_q[0]);
                        void'(exp_q.pop_front());
                        void'(exp_last_q.pop_front());
                        void'(exp_tag_q.pop_front());
                    end
                end
            end else if (pkt_done) begin
                check(1'b0, "R11", "pkt_done without byte", 1, 0);
            end
            if (pl_ready && hdr_ready) check(1'b0, "R4", "pl_ready while idle", 1, 0);
        end
    end

    // Downstream stall pattern.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // Payload source: pops on handshake and keeps valid until taken.
    bit fed;
    always @(negedge clk) fed = pl_valid && pl_ready;
    always @(posedge clk) begin
        #2;
        if (fed) begin
            void'(feed_q.pop_front());
            void'(feed_last_q.pop_front());
            pl_valid = 1'b0;
        end
        if (!pl_valid && feed_q.size() != 0 && !(gap_en && lfsr[5] && lfsr[7])) pl_valid = 1'b1;
        if (feed_q.size() == 0) pl_valid = 1'b0;
        pl_data = (feed_q.size() != 0) ? feed_q[0] : 8'h00;
        pl_last = (feed_q.size() != 0) ? feed_last_q[0] : 1'b0;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(hdr_ready == 1'b1, "R1", "reset hdr_ready", hdr_ready, 1);
        check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        check(pl_ready == 1'b0, "R4", "reset pl_ready", pl_ready, 0);
        check(len_err == 1'b0, "R13", "reset len_err", len_err, 0);
        check(pkt_done == 1'b0, "R11", "reset pkt_done", pkt_done, 0);

        send_pkt(2'd0, 6'h3E, 5, 1'b1, 1'b1, 5, 8'h10);      // R5 exact length
        send_pkt(2'd1, 6'h29, 0, 1'b1, 1'b1, 0, 8'h00);      // R6 empty payload
        send_pkt(2'd2, 6'h29, 0, 1'b1, 1'b0, 0, 8'h00);      // R7 empty, checksum off
        send_pkt(2'd3, 6'h1E, 4, 1'b1, 1'b0, 4, 8'hA0);      // R7 checksum off
        send_pkt(2'd1, 6'h05, 16'h3A, 1'b0, 1'b1, 0, 8'h00); // R8 short packet
        stall_en = 1'b1; gap_en = 1'b1;
        send_pkt(2'd0, 6'h2E, 40, 1'b1, 1'b1, 40, 8'h5A);    // R12 under stalls
        send_pkt(2'd2, 6'h0E, 6, 1'b1, 1'b1, 2, 8'hC3);      // R9 early end
        send_pkt(2'd0, 6'h3E, 1, 1'b1, 1'b1, 1, 8'hE7);      // R13 error cleared
        send_pkt(2'd3, 6'h3E, 3, 1'b1, 1'b1, 6, 8'h21);      // R10 excess bytes
        send_pkt(2'd1, 6'h11, 16'hBEEF, 1'b0, 1'b0, 0, 8'h00); // R8 short, other data
        send_pkt(2'd0, 6'h3E, 300, 1'b1, 1'b1, 300, 8'h01);  // R5 longer run
        stall_en = 1'b0; gap_en = 1'b0;
        send_pkt(2'd2, 6'h39, 2, 1'b1, 1'b1, 2, 8'hFF);      // R4 back-to-back

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule